// File: doc/BRIEF.md
# Bus Event Comparator

This block watches every bus cycle of a monitored 16-bit processor and evaluates several independent event definitions against it. Each event combines up to four terms: an address term (one exact address or an inclusive window), a data term (a 16-bit comparison with a selectable relation and per-bit don't-care masking), a cycle-type qualifier set, and an external trigger input with programmable polarity. Each event drives a hit output. The hit goes high for exactly one clock, one clock after a qualifying bus cycle.

Each event holds five configuration words. They are loaded through a small write port that selects the event and the word. A written value takes effect for bus cycles presented from the following clock onward. Counting, sequencing and trace capture sit downstream of the hit outputs and are outside this block.

Top module: `bus_event_match`

## Requirements
- R1: After reset every configuration word of every event is zero and `evt_hit` is 0. While an event's enable bit (control bit 0) is 0, that event never hits.
- R2: `evt_hit[i]` is registered. It is 1 in the cycle after a clock edge at which `bus_valid` was 1, event i was enabled, and every enabled term was true. Otherwise it is 0. A hit is therefore a one-cycle pulse for each qualifying bus cycle.
- R3: With the address term enabled (control bit 1) and single mode selected (control bit 2 = 0), the term is true only when `bus_addr` equals the low address word (select 1).
- R4: With the address term enabled and range mode selected (control bit 2 = 1), the term is true when low word ≤ `bus_addr` ≤ high word (select 2). Both bounds are inclusive.
- R5: With the data term enabled (control bit 3), relation 0 (equal) is true when `bus_data` matches the pattern word (select 3) on every bit whose mask word (select 4) bit is 0. Relation 1 (not equal) is the inverse. Mask bit 1 means don't care. The relation sits in control bits 5:4.
- R6: Relation 2 (less than) is true when `bus_data` < pattern as unsigned values, and relation 3 (greater than) when `bus_data` > pattern. In both cases the masked bits are cleared to zero on both operands first.
- R7: `bus_kind` is one-hot per bus cycle: bit 0 read, bit 1 write, bit 2 I/O, bit 3 instruction fetch, bit 4 operand read. With the qualifier term enabled (control bit 6), the term is true when the current kind bit is set in the qualifier set (control bits 11:7).
- R8: With the external term enabled (control bit 12), the term is true when `ext_in` equals the polarity bit (control bit 13). Polarity 1 means active high.
- R9: A disabled term counts as true, whatever its comparison words hold.
- R10: A write with `cfg_we` = 1 updates word `cfg_sel` (0 control, 1 low address, 2 high address, 3 pattern, 4 mask) of event `cfg_evt` only. A write to an event index of 3 or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_evt | input | 2 | Event index of the write |
| cfg_sel | input | 3 | Word select of the write |
| cfg_wdata | input | 16 | Write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 16 | Bus data |
| bus_kind | input | 5 | One-hot cycle type |
| ext_in | input | 1 | External trigger input |
| evt_hit | output | 3 | Registered hit pulse per event |

## Verification
The assertions assume that `bus_kind` is exactly one-hot whenever `bus_valid` is high. One property checks this assumption directly. The stimulus drives a single named kind constant on every bus cycle and holds `bus_valid` low on configuration-write cycles. The per-hit properties compare a hit against the inputs and configuration one cycle earlier. The bench therefore changes configuration only through the write port and predicts each hit from its own copy of the written words.

// File: rtl/bem_pkg.sv
package bem_pkg;
   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_NE = 2'd1,
      REL_LT = 2'd2,
      REL_GT = 2'd3
   } rel_e;

   localparam int NUM_KINDS = 5;
   localparam int NUM_WORDS = 5;
   localparam int SEL_W     = 3;

   // configuration word selects
   localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
   localparam logic [SEL_W-1:0] SEL_ALO  = 3'd1;
   localparam logic [SEL_W-1:0] SEL_AHI  = 3'd2;
   localparam logic [SEL_W-1:0] SEL_PAT  = 3'd3;
   localparam logic [SEL_W-1:0] SEL_MASK = 3'd4;

   // control word bit positions
   localparam int CB_EVT_EN  = 0;
   localparam int CB_ADDR_EN = 1;
   localparam int CB_RANGE   = 2;
   localparam int CB_DATA_EN = 3;
   localparam int CB_REL_LO  = 4;
   localparam int CB_QUAL_EN = 6;
   localparam int CB_QUAL_LO = 7;
   localparam int CB_EXT_EN  = 12;
   localparam int CB_EXT_POL = 13;
   localparam int CTRL_BITS  = 14;
endpackage

// File: rtl/bem_addr_term.sv
module bem_addr_term #(
   parameter int ADDR_W    = 16,
   parameter bit HAS_RANGE = 1'b1
) (
   input  logic              en,
   input  logic              range_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   output logic              match
);
   logic exact;
   logic in_win;

   assign exact = (addr == lo);

   generate
      if (HAS_RANGE) begin : g_window
         assign in_win = (addr >= lo) && (addr <= hi);
      end else begin : g_exact_only
         logic unused_hi;
         assign unused_hi = ^hi;
         assign in_win    = exact;
      end
   endgenerate

   assign match = !en || (range_mode ? in_win : exact);
endmodule

// File: rtl/bem_data_term.sv
module bem_data_term
   import bem_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter bit HAS_MAGNITUDE = 1'b1
) (
   input  logic              en,
   input  rel_e              rel,
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] pattern,
   input  logic [DATA_W-1:0] mask,
   output logic              match
);
   logic [DATA_W-1:0] care;
   logic [DATA_W-1:0] lhs;
   logic [DATA_W-1:0] rhs;
   logic              is_eq;
   logic              is_lt;
   logic              is_gt;
   logic              rel_ok;

   assign care  = ~mask;
   assign lhs   = data & care;
   assign rhs   = pattern & care;
   assign is_eq = (lhs == rhs);

   generate
      if (HAS_MAGNITUDE) begin : g_mag
         assign is_lt = (lhs < rhs);
         assign is_gt = (lhs > rhs);
      end else begin : g_no_mag
         assign is_lt = 1'b0;
         assign is_gt = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (rel)
         REL_EQ:  rel_ok = is_eq;
         REL_NE:  rel_ok = !is_eq;
         REL_LT:  rel_ok = is_lt;
         default: rel_ok = is_gt;
      endcase
   end

   assign match = !en || rel_ok;
endmodule

// File: rtl/bem_event.sv
module bem_event
   import bem_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 16,
   parameter int CFG_W         = 16,
   parameter bit HAS_RANGE     = 1'b1,
   parameter bit HAS_MAGNITUDE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic [CFG_W-1:0]     wr_data,
   input  logic                 bus_valid,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_data,
   input  logic [NUM_KINDS-1:0] bus_kind,
   input  logic                 ext_in,
   output logic                 hit
);
   logic [CTRL_BITS-1:0] ctrl_q;
   logic [ADDR_W-1:0]    alo_q, ahi_q;
   logic [DATA_W-1:0]    pat_q, mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         alo_q  <= '0;
         ahi_q  <= '0;
         pat_q  <= '0;
         mask_q <= '0;
      end else if (wr_en) begin
         unique case (wr_sel)
            SEL_CTRL: ctrl_q <= wr_data[CTRL_BITS-1:0];
            SEL_ALO:  alo_q  <= wr_data[ADDR_W-1:0];
            SEL_AHI:  ahi_q  <= wr_data[ADDR_W-1:0];
            SEL_PAT:  pat_q  <= wr_data[DATA_W-1:0];
            SEL_MASK: mask_q <= wr_data[DATA_W-1:0];
            default:  ;
         endcase
      end
   end

   logic                 evt_en, addr_en, range_mode, data_en, qual_en, ext_en, ext_pol;
   rel_e                 rel;
   logic [NUM_KINDS-1:0] qual_set;

   assign evt_en     = ctrl_q[CB_EVT_EN];
   assign addr_en    = ctrl_q[CB_ADDR_EN];
   assign range_mode = ctrl_q[CB_RANGE];
   assign data_en    = ctrl_q[CB_DATA_EN];
   assign rel        = rel_e'(ctrl_q[CB_REL_LO +: 2]);
   assign qual_en    = ctrl_q[CB_QUAL_EN];
   assign qual_set   = ctrl_q[CB_QUAL_LO +: NUM_KINDS];
   assign ext_en     = ctrl_q[CB_EXT_EN];
   assign ext_pol    = ctrl_q[CB_EXT_POL];

   logic addr_ok, data_ok, qual_ok, ext_ok;

   bem_addr_term #(.ADDR_W(ADDR_W), .HAS_RANGE(HAS_RANGE)) u_addr (
      .en(addr_en), .range_mode(range_mode), .addr(bus_addr),
      .lo(alo_q), .hi(ahi_q), .match(addr_ok)
   );

   bem_data_term #(.DATA_W(DATA_W), .HAS_MAGNITUDE(HAS_MAGNITUDE)) u_data (
      .en(data_en), .rel(rel), .data(bus_data), .pattern(pat_q),
      .mask(mask_q), .match(data_ok)
   );

   assign qual_ok = !qual_en || ((bus_kind & qual_set) != '0);
   assign ext_ok  = !ext_en || (ext_in == ext_pol);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit <= 1'b0;
      else        hit <= bus_valid && evt_en && addr_ok && data_ok && qual_ok && ext_ok;
   end

   // hits only follow a valid bus cycle on an enabled event
   assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ($past(bus_valid) && $past(evt_en)));

   assert_disabled_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(evt_en) |-> !hit);

   assert_single_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && $past(addr_en) && !$past(range_mode)) |-> ($past(bus_addr) == $past(alo_q)));

   assert_range_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && $past(addr_en) && $past(range_mode) && HAS_RANGE)
         |-> ($past(bus_addr) >= $past(alo_q) && $past(bus_addr) <= $past(ahi_q)));

   assert_data_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && $past(data_en) && $past(rel) == REL_EQ)
         |-> ((($past(bus_data) ^ $past(pat_q)) & ~$past(mask_q)) == '0));

   assert_data_less_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && $past(data_en) && $past(rel) == REL_LT)
         |-> (($past(bus_data) & ~$past(mask_q)) < ($past(pat_q) & ~$past(mask_q))));

   assert_qualifier_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && $past(qual_en)) |-> (($past(bus_kind) & $past(qual_set)) != '0));

   assert_ext_polarity_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && $past(ext_en)) |-> ($past(ext_in) == $past(ext_pol)));
endmodule

// File: rtl/bus_event_match.sv
module bus_event_match
   import bem_pkg::*;
#(
   parameter int NUM_EVT       = 3,
   parameter int EVT_SEL_W     = 2,
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 16,
   parameter int CFG_W         = 16,
   parameter bit HAS_RANGE     = 1'b1,
   parameter bit HAS_MAGNITUDE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [EVT_SEL_W-1:0] cfg_evt,
   input  logic [2:0]           cfg_sel,
   input  logic [CFG_W-1:0]     cfg_wdata,
   input  logic                 bus_valid,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_data,
   input  logic [4:0]           bus_kind,
   input  logic                 ext_in,
   output logic [NUM_EVT-1:0]   evt_hit
);
   localparam int EVT_SLOTS = 1 << EVT_SEL_W;

   generate
      if (NUM_EVT < 1 || NUM_EVT > EVT_SLOTS) begin : g_bad_evt
         $error("NUM_EVT must be between 1 and 2**EVT_SEL_W");
      end
      if (CFG_W < ADDR_W || CFG_W < DATA_W || CFG_W < CTRL_BITS) begin : g_bad_cfg
         $error("CFG_W too narrow for address, data or control word");
      end
      if (SEL_W != 3) begin : g_bad_sel
         $error("word select width must be 3");
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
         logic wr_this;
         assign wr_this = cfg_we && (cfg_evt == EVT_SEL_W'(i));

         bem_event #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W),
            .HAS_RANGE(HAS_RANGE), .HAS_MAGNITUDE(HAS_MAGNITUDE)
         ) u_evt (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_this), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
            .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
            .bus_kind(bus_kind), .ext_in(ext_in), .hit(evt_hit[i])
         );
      end
   endgenerate

   // input contract: one cycle type per valid bus cycle
   assert_kind_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> $onehot(bus_kind));
endmodule

// File: tb/sim_bus_event_match.sv
`timescale 1ns/1ps
module sim_bus_event_match;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_evt = '0;
   logic [2:0]  cfg_sel = '0;
   logic [15:0] cfg_wdata = '0;
   logic        bus_valid = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_data = '0;
   logic [4:0]  bus_kind = 5'b00001;
   logic        ext_in = 1'b0;
   logic [2:0]  evt_hit;

   always #2.5 clk = ~clk;

   bus_event_match u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_evt(cfg_evt),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bus_valid(bus_valid),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_kind(bus_kind),
      .ext_in(ext_in), .evt_hit(evt_hit)
   );

   localparam logic [4:0] K_RD = 5'b00001, K_WR = 5'b00010, K_IO = 5'b00100,
                          K_IF = 5'b01000, K_OP = 5'b10000;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [15:0] sh [3][5];
   logic [2:0]  qexp [$];
   string       qtag [$];

   function automatic logic [15:0] ctl(bit a_en, bit rng, bit d_en, logic [1:0] rel,
                                       bit q_en, logic [4:0] q, bit x_en, bit pol);
      return {2'b00, pol, x_en, q, q_en, rel, d_en, rng, a_en, 1'b1};
   endfunction

   function automatic logic model(int e, logic [15:0] a, logic [15:0] d,
                                  logic [4:0] k, logic x, logic v);
      logic [15:0] c, m, l, r;
      logic am, dm, qm, xm;
      c = sh[e][0];
      if (!v || !c[0]) return 1'b0;
      am = !c[1] || (c[2] ? (a >= sh[e][1] && a <= sh[e][2]) : (a == sh[e][1]));
      m = ~sh[e][4]; l = d & m; r = sh[e][3] & m;
      case (c[5:4])
         2'd0: dm = (l == r);
         2'd1: dm = (l != r);
         2'd2: dm = (l < r);
         default: dm = (l > r);
      endcase
      dm = !c[3] || dm;
      qm = !c[6] || ((k & c[11:7]) != 0);
      xm = !c[12] || (x == c[13]);
      return am && dm && qm && xm;
   endfunction

   task automatic wcfg(int e, int s, logic [15:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_evt = 2'(e); cfg_sel = 3'(s); cfg_wdata = val;
      bus_valid = 1'b0;
      qexp.push_back(3'b000); qtag.push_back("R10");
      if (e < 3) sh[e][s] = val;
   endtask

   task automatic cyc(logic [15:0] a, logic [15:0] d, logic [4:0] k, logic x,
                      logic v, string tag);
      logic [2:0] e;
      @(negedge clk);
      cfg_we = 1'b0;
      bus_valid = v; bus_addr = a; bus_data = d; bus_kind = k; ext_in = x;
      for (int i = 0; i < 3; i++) e[i] = model(i, a, d, k, x, v);
      qexp.push_back(e); qtag.push_back(tag);
   endtask

   // monitor: pops expectations and compares after each edge
   always @(posedge clk) begin
      #1;
      if (qexp.size() > 0) begin
         logic [2:0] ex;
         string t;
         ex = qexp.pop_front();
         t = qtag.pop_front();
         checks++;
         if (evt_hit !== ex) begin
            errors++;
            $display("FAIL %s: evt_hit actual %b expected %b", t, evt_hit, ex);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int e = 0; e < 3; e++) for (int s = 0; s < 5; s++) sh[e][s] = '0;
      repeat (3) @(negedge clk);
      checks++;
      if (evt_hit !== 3'b000) begin
         errors++; $display("FAIL R1: reset evt_hit actual %b expected 000", evt_hit);
      end
      rst_n = 1'b1;
      // R1: nothing enabled yet
      cyc(16'h0000, 16'h0000, K_RD, 1'b0, 1'b1, "R1");
      cyc(16'hFFFF, 16'h1234, K_WR, 1'b1, 1'b1, "R1");

      // R3 single address on event 0
      wcfg(0, 1, 16'h1234);
      wcfg(0, 0, ctl(1, 0, 0, 2'd0, 0, 5'd0, 0, 0));
      cyc(16'h1234, 16'h0, K_RD, 0, 1, "R3");
      cyc(16'h1235, 16'h0, K_RD, 0, 1, "R3");
      cyc(16'h1233, 16'h0, K_RD, 0, 1, "R3");
      cyc(16'h1234, 16'h0, K_RD, 0, 0, "R2");
      cyc(16'h1234, 16'h0, K_RD, 0, 1, "R2");

      // R4 inclusive range on event 1
      wcfg(1, 1, 16'h0100);
      wcfg(1, 2, 16'h01FF);
      wcfg(1, 0, ctl(1, 1, 0, 2'd0, 0, 5'd0, 0, 0));
      cyc(16'h00FF, 16'h0, K_RD, 0, 1, "R4");
      cyc(16'h0100, 16'h0, K_RD, 0, 1, "R4");
      cyc(16'h0180, 16'h0, K_RD, 0, 1, "R4");
      cyc(16'h01FF, 16'h0, K_RD, 0, 1, "R4");
      cyc(16'h0200, 16'h0, K_RD, 0, 1, "R4");

      // R5 masked equal / not equal on event 2
      wcfg(2, 3, 16'hA5F0);
      wcfg(2, 4, 16'h000F);
      wcfg(2, 0, ctl(0, 0, 1, 2'd0, 0, 5'd0, 0, 0));
      cyc(16'h0, 16'hA5FF, K_RD, 0, 1, "R5");
      cyc(16'h0, 16'hA4F0, K_RD, 0, 1, "R5");
      wcfg(2, 0, ctl(0, 0, 1, 2'd1, 0, 5'd0, 0, 0));
      cyc(16'h0, 16'hA5F3, K_RD, 0, 1, "R5");
      cyc(16'h0, 16'hA4F0, K_RD, 0, 1, "R5");

      // R6 magnitude after masking
      wcfg(2, 3, 16'h8000);
      wcfg(2, 4, 16'h00FF);
      wcfg(2, 0, ctl(0, 0, 1, 2'd2, 0, 5'd0, 0, 0));
      cyc(16'h0, 16'h7FFF, K_RD, 0, 1, "R6");
      cyc(16'h0, 16'h80FF, K_RD, 0, 1, "R6");
      cyc(16'h0, 16'h8100, K_RD, 0, 1, "R6");
      wcfg(2, 0, ctl(0, 0, 1, 2'd3, 0, 5'd0, 0, 0));
      cyc(16'h0, 16'h81FF, K_RD, 0, 1, "R6");
      cyc(16'h0, 16'h80AA, K_RD, 0, 1, "R6");
      cyc(16'h0, 16'h7FFF, K_RD, 0, 1, "R6");

      // R7 qualifier set {write, fetch} on event 0
      wcfg(0, 0, ctl(0, 0, 0, 2'd0, 1, K_WR | K_IF, 0, 0));
      cyc(16'h0, 16'h0, K_RD, 0, 1, "R7");
      cyc(16'h0, 16'h0, K_WR, 0, 1, "R7");
      cyc(16'h0, 16'h0, K_IO, 0, 1, "R7");
      cyc(16'h0, 16'h0, K_IF, 0, 1, "R7");
      cyc(16'h0, 16'h0, K_OP, 0, 1, "R7");

      // R8 external polarity on event 1
      wcfg(1, 0, ctl(0, 0, 0, 2'd0, 0, 5'd0, 1, 1));
      cyc(16'h0, 16'h0, K_RD, 1, 1, "R8");
      cyc(16'h0, 16'h0, K_RD, 0, 1, "R8");
      wcfg(1, 0, ctl(0, 0, 0, 2'd0, 0, 5'd0, 1, 0));
      cyc(16'h0, 16'h0, K_RD, 1, 1, "R8");
      cyc(16'h0, 16'h0, K_RD, 0, 1, "R8");

      // R9 disabled terms with stale words are true
      wcfg(0, 0, ctl(0, 0, 0, 2'd0, 0, 5'd0, 0, 0));
      cyc(16'h4321, 16'hBEEF, K_OP, 0, 1, "R9");
      cyc(16'h1234, 16'h0000, K_IO, 1, 1, "R9");

      // R2 all four terms together on event 2
      wcfg(2, 1, 16'h0040);
      wcfg(2, 3, 16'h00FF);
      wcfg(2, 4, 16'h0000);
      wcfg(2, 0, ctl(1, 0, 1, 2'd0, 1, K_RD, 1, 1));
      cyc(16'h0040, 16'h00FF, K_RD, 1, 1, "R2");
      cyc(16'h0041, 16'h00FF, K_RD, 1, 1, "R2");
      cyc(16'h0040, 16'h00FE, K_RD, 1, 1, "R2");
      cyc(16'h0040, 16'h00FF, K_WR, 1, 1, "R2");
      cyc(16'h0040, 16'h00FF, K_RD, 0, 1, "R2");
      cyc(16'h0040, 16'h00FF, K_RD, 1, 0, "R2");

      // R10 out-of-range event index ignored; events independent
      wcfg(3, 0, 16'h0000);
      wcfg(3, 1, 16'h9999);
      cyc(16'h0040, 16'h00FF, K_RD, 1, 1, "R10");
      cyc(16'h0040, 16'h00FF, K_RD, 0, 1, "R10");
      wcfg(1, 0, ctl(1, 1, 0, 2'd0, 0, 5'd0, 0, 0));
      cyc(16'h0040, 16'h00FF, K_RD, 1, 1, "R10");
      cyc(16'h0150, 16'h00FF, K_RD, 1, 1, "R10");

      @(negedge clk);
      bus_valid = 1'b0; cfg_we = 1'b0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule